// File: doc/BRIEF.md
# Serially programmed quad delay line

This block carries four one-bit signals through four independent delay channels that run on a sample clock. Each channel passes its input to its output without inverting it, so rising and falling edges are both shifted by the same number of cycles. The delay of a channel is a fixed base plus a 4-bit address times a step size. The base and the step are counted in sample-clock cycles and are set as parameters.

A three-wire serial port sets the four addresses and the four channel enables. It has a serial clock, serial data and a load strobe. Bits are first shifted into a 20-bit staging register and have no effect until the load strobe copies that register into the live configuration. The most significant bit of the staging register is driven out on a serial output, so several blocks can share one chain. The serial inputs are asynchronous to the sample clock and are resynchronised before use. A disabled channel drives a constant low.

Top module: `quad_delay_line`

## Requirements
- R1: The four channels are independent. Each channel uses only its own address and its own enable, so different addresses give different delays at the same time.
- R2: While channel k is enabled with address A (0 to 15), sig_out[k] just after clock edge e equals sig_in[k] as sampled at clock edge e-(BASE_CYC + A*STEP_CYC + 1). Address 0 gives the shortest delay and address 15 the longest.
- R3: The output is never inverted. Single-cycle high pulses, single-cycle low pulses and long levels all come out unchanged in shape after the same delay.
- R4: A rising edge of ser_clk that is first seen high at clock edge c shifts ser_din, also sampled at edge c, into bit 0 of the 20-bit staging register at edge c+2, and all other bits move up by one. ser_dout always shows bit 19. The staging register changes at no other time.
- R5: Bits are sent most significant first, so the first bit sent ends in bit 19. The staging-register layout is: bits 19..16 are the channel 0 address, 15..12 channel 1, 11..8 channel 2, 7..4 channel 3 (most significant bit first within each field), and bits 3..0 are the enables of channels 0, 1, 2 and 3 in that order. An enable bit of 1 means enabled.
- R6: A rising edge of ser_load that is first seen high at clock edge c copies the staging register into the live addresses and enables at edge c+2. The new delays are visible on sig_out from edge c+3. Shifting without a load never changes any delay.
- R7: A disabled channel holds sig_out low for as long as it stays disabled, whatever its input does.
- R8: While rst is high, sig_out and ser_dout are 0. Reset clears the staging register, all addresses and all delay lines to zero and leaves every channel enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_din | input | 1 | Serial data in, asynchronous |
| ser_load | input | 1 | Load strobe that copies the staging register into the live configuration, asynchronous |
| ser_dout | output | 1 | Top bit of the staging register, used for chaining |
| sig_in | input | NUM_CH | Signal inputs, one bit per channel |
| sig_out | output | NUM_CH | Delayed signal outputs, one bit per channel |

## Verification
The hardest case to reach from the ports is a staging register that is half full while the channels keep running. The live delays must stay frozen, and they must then switch on one exact cycle when the load strobe is finally seen. The stimulus shifts only part of a word while the inputs keep toggling, checks every output on every cycle, and then completes and loads the word. A reference model built on cycle-indexed histories of the serial pins predicts the switching cycle. The daisy-chain path is exercised by shifting a loaded word back out through ser_dout while new zero bits go in.

// File: rtl/qdl_pkg.sv
package qdl_pkg;
  localparam int NUM_CH = 4;
  localparam int ADDR_W = 4;

  // Number of taps a channel needs: base plus largest address times step, plus one.
  function automatic int line_depth(input int base_cyc, input int step_cyc, input int addr_w);
    return base_cyc + ((1 << addr_w) - 1) * step_cyc + 1;
  endfunction
endpackage

// File: rtl/qdl_sync.sv
module qdl_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1, stage2;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;
endmodule

// File: rtl/qdl_serial_port.sv
module qdl_serial_port #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 4,
  localparam int WORD_W = NUM_CH * (ADDR_W + 1),
  localparam int AFLD_W = NUM_CH * ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              sdi_s,
  input  logic              load_s,
  output logic              sdo_o,
  output logic [AFLD_W-1:0] addr_o,
  output logic [NUM_CH-1:0] en_o
);
  logic              sclk_d, load_d;
  logic              sclk_rise, load_rise;
  logic [WORD_W-1:0] stage_q;
  logic [AFLD_W-1:0] addr_q;
  logic [NUM_CH-1:0] en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      load_d <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      load_d <= load_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_d;
  assign load_rise = load_s & ~load_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
    end else if (sclk_rise) begin
      stage_q <= {stage_q[WORD_W-2:0], sdi_s};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      en_q   <= '1;
    end else if (load_rise) begin
      addr_q <= stage_q[WORD_W-1 -: AFLD_W];
      en_q   <= stage_q[NUM_CH-1:0];
    end
  end

  assign sdo_o  = stage_q[WORD_W-1];
  assign addr_o = addr_q;
  assign en_o   = en_q;

  // R4: a detected serial clock edge lasts exactly one sample cycle
  p_single_rise_r4: assert property (@(posedge clk) disable iff (rst)
    sclk_rise |=> !sclk_rise);

  // R4: after a shift the bit below the top has moved onto the chain output
  p_shift_out_r4: assert property (@(posedge clk) disable iff (rst)
    sclk_rise |=> sdo_o == $past(stage_q[WORD_W-2]));

  // R4: no serial clock edge, no movement in the staging register
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !sclk_rise |=> $stable(stage_q));

  // R6: live configuration moves only on a load edge
  p_hold_cfg_r6: assert property (@(posedge clk) disable iff (rst)
    !load_rise |=> ($stable(addr_o) && $stable(en_o)));
endmodule

// File: rtl/qdl_channel.sv
module qdl_channel #(
  parameter int BASE_CYC = 2,
  parameter int STEP_CYC = 3,
  parameter int ADDR_W   = 4,
  localparam int DEPTH   = qdl_pkg::line_depth(BASE_CYC, STEP_CYC, ADDR_W),
  localparam int TAP_W   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              din_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              en_i,
  output logic              dout_o
);
  logic [DEPTH-1:0] line_q;
  logic [TAP_W-1:0] tap;

  assign tap = TAP_W'(BASE_CYC) + TAP_W'(addr_i) * TAP_W'(STEP_CYC);

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= '0;
      dout_o <= 1'b0;
    end else begin
      line_q <= {line_q[DEPTH-2:0], din_i};
      dout_o <= en_i & line_q[tap];
    end
  end

  // R7: a channel that was disabled drives low on the next cycle
  p_disabled_low_r7: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !dout_o);
endmodule

// File: rtl/quad_delay_line.sv
module quad_delay_line #(
  parameter int BASE_CYC = 2,
  parameter int STEP_CYC = 3,
  parameter int NUM_CH   = qdl_pkg::NUM_CH,
  parameter int ADDR_W   = qdl_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk,
  input  logic              ser_din,
  input  logic              ser_load,
  output logic              ser_dout,
  input  logic [NUM_CH-1:0] sig_in,
  output logic [NUM_CH-1:0] sig_out
);
  localparam int AFLD_W = NUM_CH * ADDR_W;

  logic              sclk_s, load_s, sdi_s;
  logic [AFLD_W-1:0] addr_all;
  logic [NUM_CH-1:0] en_all;

  qdl_sync #(.W(3)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ser_clk, ser_load, ser_din}),
    .q   ({sclk_s, load_s, sdi_s})
  );

  qdl_serial_port #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_port (
    .clk    (clk),
    .rst    (rst),
    .sclk_s (sclk_s),
    .sdi_s  (sdi_s),
    .load_s (load_s),
    .sdo_o  (ser_dout),
    .addr_o (addr_all),
    .en_o   (en_all)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    qdl_channel #(.BASE_CYC(BASE_CYC), .STEP_CYC(STEP_CYC), .ADDR_W(ADDR_W)) u_ch (
      .clk    (clk),
      .rst    (rst),
      .din_i  (sig_in[g]),
      .addr_i (addr_all[(NUM_CH-1-g)*ADDR_W +: ADDR_W]),
      .en_i   (en_all[NUM_CH-1-g]),
      .dout_o (sig_out[g])
    );
  end
endmodule

// File: tb/quad_delay_line_tb_top.sv
`timescale 1ns/1ps
module quad_delay_line_tb_top;
  localparam int BASE = 2;
  localparam int STEP = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ser_clk = 1'b0, ser_din = 1'b0, ser_load = 1'b0;
  logic       ser_dout;
  logic [3:0] sig_in = 4'h0;
  logic [3:0] sig_out;

  always #4 clk = ~clk;

  quad_delay_line #(.BASE_CYC(BASE), .STEP_CYC(STEP)) dut_i (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_din(ser_din), .ser_load(ser_load),
    .ser_dout(ser_dout), .sig_in(sig_in), .sig_out(sig_out)
  );

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  string tag = "R2";

  // reference model: cycle-indexed histories of every input
  logic [3:0]  din_h [0:255];
  logic        sclk_h[0:255];
  logic        load_h[0:255];
  logic        sdi_h [0:255];
  logic [19:0] m_stage;
  int          m_addr[4];
  logic [3:0]  m_en;
  logic [3:0]  exp_out;
  logic        exp_sdo;
  int          cyc;

  function automatic int ix(input int c);
    return (c + 1024) % 256;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      cyc = 0;
      for (int i = 0; i < 256; i++) begin
        din_h[i] = 4'h0; sclk_h[i] = 1'b0; load_h[i] = 1'b0; sdi_h[i] = 1'b0;
      end
      m_stage = 20'h0;
      for (int k = 0; k < 4; k++) m_addr[k] = 0;
      m_en = 4'hF;
      exp_out = 4'h0;
      exp_sdo = 1'b0;
    end else begin
      cyc = cyc + 1;
      din_h[ix(cyc)]  = sig_in;
      sclk_h[ix(cyc)] = ser_clk;
      load_h[ix(cyc)] = ser_load;
      sdi_h[ix(cyc)]  = ser_din;
      for (int k = 0; k < 4; k++) begin
        int t;
        t = BASE + m_addr[k] * STEP;
        exp_out[k] = m_en[k] ? din_h[ix(cyc - 1 - t)][k] : 1'b0;
      end
      if (load_h[ix(cyc-2)] && !load_h[ix(cyc-3)]) begin
        for (int k = 0; k < 4; k++) m_addr[k] = int'(m_stage[19 - 4*k -: 4]);
        for (int k = 0; k < 4; k++) m_en[k] = m_stage[3 - k];
      end
      if (sclk_h[ix(cyc-2)] && !sclk_h[ix(cyc-3)])
        m_stage = {m_stage[18:0], sdi_h[ix(cyc-2)]};
      exp_sdo = m_stage[19];
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      if (rst) begin
        checks++;
        if (sig_out !== 4'h0 || ser_dout !== 1'b0) begin
          errors++;
          $display("FAIL R8 reset outputs: sig_out=%h ser_dout=%b expected 0/0", sig_out, ser_dout);
        end
      end else begin
        for (int k = 0; k < 4; k++) begin
          checks++;
          if (sig_out[k] !== exp_out[k]) begin
            errors++;
            $display("FAIL %s ch%0d cycle %0d: actual=%b expected=%b",
                     m_en[k] ? tag : "R7", k, cyc, sig_out[k], exp_out[k]);
          end
        end
        checks++;
        if (ser_dout !== exp_sdo) begin
          errors++;
          $display("FAIL R4 ser_dout cycle %0d: actual=%b expected=%b", cyc, ser_dout, exp_sdo);
        end
      end
    end
  end

  // input signal patterns: random, toggling, slow squares
  logic [15:0] lfsr = 16'hACE1;
  int          pcnt = 0;
  always @(negedge clk) begin
    if (!rst) begin
      pcnt++;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case ((pcnt / 150) % 3)
        0: sig_in = lfsr[3:0];
        1: sig_in = ~sig_in;
        default: for (int k = 0; k < 4; k++) sig_in[k] = pcnt[k+2];
      endcase
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    ser_din = b;
    wait_cyc(4);
    ser_clk = 1'b1;
    wait_cyc(4);
    ser_clk = 1'b0;
  endtask

  task automatic send_bits(input logic [19:0] w, input int hi, input int lo);
    for (int i = hi; i >= lo; i--) send_bit(w[i]);
  endtask

  task automatic pulse_load();
    wait_cyc(3);
    ser_load = 1'b1;
    wait_cyc(4);
    ser_load = 1'b0;
  endtask

  initial begin
    wait_cyc(5);
    rst = 1'b0;
    tag = "R2";                       // R2: reset addresses all 0, minimum delay
    wait_cyc(300);
    tag = "R1";                       // R1: four different delays at once
    send_bits({4'd0, 4'd5, 4'd10, 4'd15, 4'b1111}, 19, 0);
    pulse_load();
    wait_cyc(400);
    tag = "R5";                       // R5: mixed fields, channels 1 and 3 off
    send_bits({4'd15, 4'd3, 4'd7, 4'd1, 4'b1010}, 19, 0);
    pulse_load();
    wait_cyc(400);
    tag = "R6";                       // R6: half-shifted word leaves delays unchanged
    send_bits({4'd2, 4'd9, 4'd12, 4'd4, 4'b0111}, 19, 10);
    wait_cyc(200);
    send_bits({4'd2, 4'd9, 4'd12, 4'd4, 4'b0111}, 9, 0);
    wait_cyc(100);
    pulse_load();
    wait_cyc(300);
    tag = "R7";                       // R7: everything disabled
    send_bits({4'd15, 4'd15, 4'd15, 4'd15, 4'b0000}, 19, 0);
    pulse_load();
    wait_cyc(300);
    tag = "R3";                       // R3: longest delay with toggling and pulses
    send_bits({4'd15, 4'd15, 4'd15, 4'd15, 4'b1111}, 19, 0);
    pulse_load();
    wait_cyc(500);
    tag = "R4";                       // R4: chain the loaded word out via ser_dout
    send_bits(20'h00000, 19, 0);
    wait_cyc(50);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule